// File: doc/BRIEF.md
# LCD AC-Bias Waveform Generator

This block drives the polarity-reversal (AC modulation) signal of a passive liquid-crystal panel. The panel must not see a DC bias across its cells, so the drive polarity is flipped at a programmed rate. By default the flip happens once per frame, on a frame-start strobe. Software can instead program a non-zero count `n` in a small 8-bit register. The signal then flips after every `n+1` line pulses. A zero count therefore does not mean "flip every line": it selects frame-rate flipping.

The count sits in bits 7:2 of the register at address 4'b0101. Bits 1:0 of that register hold the two high-order bits of a 10-bit display line count. They have nothing to do with the waveform. They are stored, read back and driven onto an output for the panel timing logic to use. When the panel format select marks the one 8-bit single-colour format that needs no AC drive, the waveform is frozen.

A new count is loaded into the running period only when the waveform flips. A period that is already under way is therefore never cut short by a write.

Top module: `lcd_acbias_gen`

## Requirements
- R1: Synchronous active-low reset clears `wf_out`, the stored count, `line_cnt_hi` and `reg_rdata` to zero.
- R2: A cycle with `reg_wr` high and `reg_addr` equal to 4'b0101 stores `reg_wdata[7:2]` as the toggle count and `reg_wdata[1:0]` as the line-count high bits. `line_cnt_hi` shows those bits one cycle later. Writes to any other address change nothing.
- R3: A cycle with `reg_rd` high and `reg_addr` equal to 4'b0101 returns {count, line-count high bits} on `reg_rdata` one cycle later. In every other cycle `reg_rdata` is zero one cycle later.
- R4: With an active count of 0, `wf_out` inverts one cycle after each cycle in which `frame_start` is high. Line pulses have no effect on it.
- R5: With an active count `n` from 1 to 63, `wf_out` inverts one cycle after every (n+1)-th `line_pulse`, counted from the previous inversion.
- R6: A newly written count becomes the active count only at the next inversion of `wf_out`, or while the format select is high. A running period keeps its old length.
- R7: While `fmt_no_ac` is high, `wf_out` holds its level, frame and line pulses are ignored, and the line counter is cleared. After `fmt_no_ac` goes low, the first period is a full period.
- R8: With a non-zero active count, `frame_start` has no effect on `wf_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| line_pulse | input | 1 | One-cycle line pulse |
| frame_start | input | 1 | One-cycle frame-start strobe |
| fmt_no_ac | input | 1 | Panel format without AC drive; freezes the waveform |
| wf_out | output | 1 | AC-bias waveform |
| line_cnt_hi | output | 2 | Stored line-count bits 9:8 |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. A write shows on `line_cnt_hi`, and a read on `reg_rdata`, at the next edge. A qualifying frame strobe or the (n+1)-th line pulse inverts `wf_out` at the edge that samples it. The bench drives inputs on the falling edge. At the following rising edge it advances a reference model built from the requirements. One nanosecond after that edge it compares every output with the model, so each check falls in the cycle its result is due. Directed sequences cover a count of zero, the extremes 1 and 63, a write in the middle of a period, the frozen format and writes to foreign addresses. A seeded random phase then mixes all inputs.

// File: rtl/lcd_acbias_gen.sv
module lcd_acbias_gen #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 6,
  parameter int HI_W   = 2,
  parameter logic [ADDR_W-1:0] WF_REG_ADDR = 4'b0101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [CNT_W+HI_W-1:0]   reg_wdata,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  output logic [CNT_W+HI_W-1:0]   reg_rdata,
  input  logic                    line_pulse,
  input  logic                    frame_start,
  input  logic                    fmt_no_ac,
  output logic                    wf_out,
  output logic [HI_W-1:0]         line_cnt_hi
);
  localparam int DW = CNT_W + HI_W;

  logic [CNT_W-1:0] cnt_q, act_q, lp_q;
  logic [HI_W-1:0]  hi_q;
  logic             wf_q;
  logic [DW-1:0]    rd_q;

  wire hit       = (reg_addr == WF_REG_ADDR);
  wire frame_mod = (act_q == '0);
  wire last_lp   = (lp_q == act_q);
  wire toggle    = !fmt_no_ac &&
                   (frame_mod ? frame_start : (line_pulse && last_lp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else if (reg_wr && hit) begin
      cnt_q <= reg_wdata[DW-1:HI_W];
      hi_q  <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= (reg_rd && hit) ? {cnt_q, hi_q} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wf_q  <= 1'b0;
      act_q <= '0;
      lp_q  <= '0;
    end else if (fmt_no_ac) begin
      act_q <= cnt_q;
      lp_q  <= '0;
    end else if (toggle) begin
      wf_q  <= ~wf_q;
      act_q <= cnt_q;
      lp_q  <= '0;
    end else if (!frame_mod && line_pulse) begin
      lp_q  <= lp_q + 1'b1;
    end
  end

  assign wf_out      = wf_q;
  assign line_cnt_hi = hi_q;
  assign reg_rdata   = rd_q;

  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit) |=> (line_cnt_hi == $past(reg_wdata[HI_W-1:0])));  // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));  // R3
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_no_ac |=> (lp_q == '0) && $stable(wf_out));  // R7
  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pulse && !frame_start) |=> $stable(wf_out));  // R4
  AST_LP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_q <= act_q));  // R5
  AST_LINE_IGNORES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_mod && !line_pulse) |=> $stable(wf_out));  // R8
endmodule

// File: tb/tb_lcd_acbias_gen.sv
`timescale 1ns/100ps
module tb_lcd_acbias_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, line_pulse, frame_start, fmt_no_ac, wf_out;
  logic [1:0] line_cnt_hi;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [5:0] m_cnt, m_act, m_lp;
  logic [1:0] m_hi;
  logic       m_wf;
  logic [7:0] m_rd;

  always #2.5 clk = ~clk;

  lcd_acbias_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .line_pulse(line_pulse), .frame_start(frame_start), .fmt_no_ac(fmt_no_ac),
    .wf_out(wf_out), .line_cnt_hi(line_cnt_hi));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic rd, input logic [3:0] a,
                                        input logic [5:0] c, input logic [1:0] h);
    return (rd && a == 4'b0101) ? {c, h} : 8'h00;
  endfunction

  task automatic model_edge();
    logic [5:0] old_cnt;
    old_cnt = m_cnt;
    m_rd = exp_rd(reg_rd, reg_addr, m_cnt, m_hi);
    if (reg_wr && reg_addr == 4'b0101) begin
      m_cnt = reg_wdata[7:2];
      m_hi  = reg_wdata[1:0];
    end
    if (fmt_no_ac) begin
      m_lp = 0; m_act = old_cnt;
    end else if (m_act == 0) begin
      if (frame_start) begin m_wf = ~m_wf; m_act = old_cnt; m_lp = 0; end
    end else if (line_pulse) begin
      if (m_lp == m_act) begin m_wf = ~m_wf; m_act = old_cnt; m_lp = 0; end
      else m_lp = m_lp + 1;
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic rd, input logic [3:0] a,
                      input logic [7:0] d, input logic lp, input logic fs, input logic fm);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    line_pulse = lp; frame_start = fs; fmt_no_ac = fm;
    @(posedge clk);
    model_edge();
    #1;
    chk({tag, " wf"}, wf_out, m_wf);
    chk("R2 line_cnt_hi", line_cnt_hi, m_hi);
    chk("R3 rdata", reg_rdata, m_rd);
  endtask

  task automatic idle(input string tag, input int lp, input int fs, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 4'h0, 8'h00, lp[0], fs[0], 0);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    step("R2", 1, 0, a, d, 0, 0, 0);
  endtask

  task automatic rd_reg(input logic [3:0] a);
    step("R3", 0, 1, a, 8'h00, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int wf_before;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    line_pulse = 0; frame_start = 0; fmt_no_ac = 0;
    m_cnt = 0; m_act = 0; m_lp = 0; m_hi = 0; m_wf = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 wf", wf_out, 0);
    chk("R1 hi", line_cnt_hi, 0);
    chk("R1 rdata", reg_rdata, 0);
    @(negedge clk); rst_n = 1;
    rd_reg(4'b0101);
    chk("R1 count reads zero", reg_rdata, 0);

    // R4: frame mode, line pulses ignored
    idle("R4", 1, 0, 5);
    chk("R4 lp ignored", wf_out, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4 frame toggles", wf_out, 1);

    // R2: foreign address write ignored
    wr_reg(4'b0100, 8'hFF);
    rd_reg(4'b0101);
    chk("R2 foreign write ignored", reg_rdata, 0);
    rd_reg(4'b0100);
    chk("R3 foreign read zero", reg_rdata, 0);

    // R6: write n=3 takes effect at next frame toggle
    wr_reg(4'b0101, {6'd3, 2'b10});
    chk("R2 hi bits", line_cnt_hi, 2'b10);
    rd_reg(4'b0101);
    chk("R3 readback", reg_rdata, {6'd3, 2'b10});
    idle("R6", 1, 0, 3);
    chk("R6 still frame mode", wf_out, 1);
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    chk("R6 frame toggle loads n", wf_out, 0);

    // R5: n=3 -> every 4 pulses; R8 frame ignored
    idle("R8", 0, 1, 3);
    chk("R8 frame ignored", wf_out, 0);
    idle("R5", 1, 0, 3);
    chk("R5 not yet", wf_out, 0);
    idle("R5", 1, 0, 1);
    chk("R5 fourth pulse", wf_out, 1);

    // R6: mid-period write to n=1 keeps old length
    idle("R6", 1, 0, 2);
    wr_reg(4'b0101, {6'd1, 2'b01});
    idle("R6", 1, 0, 1);
    chk("R6 old period kept", wf_out, 1);
    idle("R6", 1, 0, 1);
    chk("R6 old period ends", wf_out, 0);
    idle("R5", 1, 0, 2);
    chk("R5 n=1 two pulses", wf_out, 1);

    // R7: frozen format
    idle("R5", 1, 0, 1);
    wf_before = wf_out;
    for (int i = 0; i < 6; i++) step("R7", 0, 0, 0, 0, 1, 1, 1);
    chk("R7 held", wf_out, wf_before);
    idle("R7", 1, 0, 1);
    chk("R7 full period after release", wf_out, wf_before);
    idle("R7", 1, 0, 1);
    chk("R7 period ends", wf_out, !wf_before);

    // R5: n=63
    wr_reg(4'b0101, {6'd63, 2'b11});
    idle("R5", 1, 0, 2);
    wf_before = wf_out;
    idle("R5", 1, 0, 63);
    chk("R5 n=63 before", wf_out, wf_before);
    idle("R5", 1, 0, 1);
    chk("R5 n=63 64th pulse", wf_out, !wf_before);

    // R4 return to zero count
    wr_reg(4'b0101, 8'h00);
    idle("R4", 1, 0, 64);
    idle("R4", 0, 1, 2);

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [5:0] n;
      a = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0101;
      n = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom % 6);
      d = {n, 2'($urandom)};
      step("R5 random", ($urandom % 40) == 0, ($urandom % 5) == 0, a, d,
           ($urandom % 3) == 0, ($urandom % 25) == 0, ($urandom % 50) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule